// File: doc/BRIEF.md
# Serially Programmed Set-Point Comparator

The block compares one chosen input against a programmable 8-bit threshold. A host configures it over a synchronous serial line. While the active-low select `cs_n` is held low, the host shifts in a command word on `sdi`, one bit per rising clock edge. The word picks the input channel, or channel pair, and the threshold code. Once the last threshold bit is in, the block compares the selected signals every cycle without further traffic and drives the 1-bit verdict on `dout`. This makes it suitable for on/off set-point control. Analog inputs are modelled as unsigned sample buses: channel `i` sits at `ain[i*SMP_W +: SMP_W]`, and a shared common input is `com_in`.

Each comparison is registered on a rising edge. `dout` takes that value on the next falling edge, half a cycle later. A tri-state driver is modelled by `dout_oe`. The serial link has no back-pressure and no valid/ready pair: the host owns the pace, and every rising edge with `cs_n` low consumes one bit. Releasing `cs_n` at any time abandons the word in progress.

Top module: `setpoint_cmp`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 and `dout_oe` is 0.
- R2: With `cs_n` low, 0 bits on `sdi` are ignored until a 1 (start bit) arrives. The next 12 rising edges then capture, in this order: mode (1 = differential), odd, sel, com, and the threshold code MSB first.
- R3: Single-ended (mode 0, com 0): the positive input is channel 2*sel+odd and the negative input is 0.
- R4: Pseudo-differential (mode 0, com 1): the positive input is channel 2*sel+odd and the negative input is `com_in`.
- R5: Differential (mode 1): channels pair as 0/1 (sel 0) and 2/3 (sel 1). With odd 0 the even channel is positive; with odd 1 the odd channel is positive.
- R6: The result is 1 only when positive minus negative is strictly greater than the threshold. It is therefore 0 whenever negative is at or above positive.
- R7: The first comparison is taken at the rising edge after the last threshold bit. `dout` shows each comparison from the following falling edge.
- R8: After one complete word, `dout` follows input changes every cycle with no further serial traffic.
- R9: `dout_oe` is 0 as soon as `cs_n` is high. It returns to 1 at the first rising edge that sees `cs_n` low.
- R10: While `cs_n` is low and no complete word has been taken, `dout` is 0.
- R11: Raising `cs_n` at any point discards a partial word and clears the running comparison. `dout` stays 0 until a new full word is received.
- R12: With `NCH` = 2, sel and com are ignored: single-ended uses channel odd against 0, and differential uses pair 0/1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs taken on rising edge, `dout` updated on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and floats the output |
| sdi | input | 1 | Serial command data |
| ain | input | NCH*SMP_W | Packed input channel samples |
| com_in | input | SMP_W | Common input for pseudo-differential mode |
| dout | output | 1 | Comparison result |
| dout_oe | output | 1 | Output driver enable |

## Verification
A bit counter that is off by one shows up in two ways. Either `dout` never leaves 0 after a complete word, or the threshold comes out shifted, and the boundary checks (difference equal to the threshold versus one above it) catch this on the first compare cycle. A wrong mux decode yields the verdict of a different channel within one cycle, so each mode is driven with values that give opposite results on the wrong pairing. Stale state after an aborted word shows as a 1 on `dout` before any new word completes, and the abort test watches for that across many idle cycles.

// File: rtl/spc_pkg.sv
package spc_pkg;
  parameter int THR_W = 8;
  localparam int HDR_BITS  = 4;
  localparam int WORD_BITS = HDR_BITS + THR_W;

  typedef struct packed {
    logic             diff;
    logic             odd;
    logic             sel;
    logic             use_com;
    logic [THR_W-1:0] thr;
  } cfg_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_RUN   = 2'd2
  } rx_st_t;
endpackage

// File: rtl/spc_word_rx.sv
module spc_word_rx
  import spc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sdi,
  output logic run,
  output cfg_t cfg
);
  localparam int CNT_W = $clog2(WORD_BITS);

  rx_st_t                 st;
  logic [CNT_W-1:0]       cnt;
  logic [WORD_BITS-2:0]   shreg;
  logic [WORD_BITS-1:0]   nxt;

  assign nxt = {shreg, sdi};
  assign run = (st == RX_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      shreg <= '0;
      cfg   <= '0;
    end else if (cs_n) begin
      // select released: drop whatever was in progress
      st  <= RX_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        RX_IDLE: begin
          if (sdi) begin
            st  <= RX_SHIFT;
            cnt <= '0;
          end
        end
        RX_SHIFT: begin
          shreg <= nxt[WORD_BITS-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(WORD_BITS-1)) begin
            cfg <= cfg_t'(nxt);
            st  <= RX_RUN;
          end
        end
        default: st <= RX_RUN;
      endcase
    end
  end
endmodule

// File: rtl/spc_chan_sel.sv
module spc_chan_sel #(
  parameter int NCH   = 4,
  parameter int SMP_W = 8
) (
  input  logic [NCH*SMP_W-1:0] ain,
  input  logic [SMP_W-1:0]     com_in,
  input  logic                 diff,
  input  logic                 odd,
  input  logic                 sel,
  input  logic                 use_com,
  output logic [SMP_W-1:0]     pos,
  output logic [SMP_W-1:0]     neg
);
  logic [SMP_W-1:0] ch [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_unpack
    assign ch[i] = ain[i*SMP_W +: SMP_W];
  end

  if (NCH == 4) begin : g_quad
    always_comb begin
      pos = ch[{sel, odd}];
      if (diff)         neg = ch[{sel, ~odd}];
      else if (use_com) neg = com_in;
      else              neg = '0;
    end
  end else begin : g_dual
    logic unused_ign;
    assign unused_ign = ^{sel, use_com, com_in};
    always_comb begin
      pos = ch[odd];
      neg = diff ? ch[~odd] : '0;
    end
  end
endmodule

// File: rtl/spc_cmp_out.sv
module spc_cmp_out #(
  parameter int SMP_W = 8,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             run,
  input  logic [SMP_W-1:0] pos,
  input  logic [SMP_W-1:0] neg,
  input  logic [THR_W-1:0] thr,
  output logic             cmp_res,
  output logic             cmp_vld,
  output logic             dout,
  output logic             dout_oe
);
  localparam int DW = SMP_W + 2;

  logic [DW-1:0] dlt;
  logic          res;
  logic          oe_q;

  assign dlt = {2'b00, pos} - {2'b00, neg};
  assign res = !dlt[DW-1] && (dlt[DW-2:0] > (DW-1)'(thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      cmp_res <= 1'b0;
      cmp_vld <= 1'b0;
    end else begin
      oe_q <= !cs_n;
      if (run && !cs_n) begin
        cmp_res <= res;
        cmp_vld <= 1'b1;
      end else begin
        cmp_res <= 1'b0;
        cmp_vld <= 1'b0;
      end
    end
  end

  // result presented half a cycle after it was taken
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                 dout <= 1'b0;
    else if (cmp_vld && !cs_n)  dout <= cmp_res;
    else                        dout <= 1'b0;
  end

  assign dout_oe = oe_q & ~cs_n;
endmodule

// File: rtl/setpoint_cmp.sv
module setpoint_cmp
  import spc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SMP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sdi,
  input  logic [NCH*SMP_W-1:0] ain,
  input  logic [SMP_W-1:0]     com_in,
  output logic                 dout,
  output logic                 dout_oe
);
  cfg_t             cfg;
  logic             run;
  logic [SMP_W-1:0] pos;
  logic [SMP_W-1:0] neg;
  logic             cmp_res;
  logic             cmp_vld;

  spc_word_rx u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sdi   (sdi),
    .run   (run),
    .cfg   (cfg)
  );

  spc_chan_sel #(.NCH(NCH), .SMP_W(SMP_W)) u_sel (
    .ain     (ain),
    .com_in  (com_in),
    .diff    (cfg.diff),
    .odd     (cfg.odd),
    .sel     (cfg.sel),
    .use_com (cfg.use_com),
    .pos     (pos),
    .neg     (neg)
  );

  spc_cmp_out #(.SMP_W(SMP_W), .THR_W(THR_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .run     (run),
    .pos     (pos),
    .neg     (neg),
    .thr     (cfg.thr),
    .cmp_res (cmp_res),
    .cmp_vld (cmp_vld),
    .dout    (dout),
    .dout_oe (dout_oe)
  );
endmodule

// File: rtl/spc_chk.sv
module spc_chk
  import spc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic dout,
  input logic dout_oe,
  input logic run,
  input cfg_t cfg,
  input logic cmp_res,
  input logic cmp_vld
);
  // R9
  oe_off_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !dout_oe);

  // R11
  abort_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !run);

  // R10
  high_needs_program_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout |-> $past(run));

  // R7
  dout_tracks_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld && !cs_n) |-> (dout == cmp_res));

  // R8
  cfg_held_while_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cfg));
endmodule

bind setpoint_cmp spc_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .dout    (dout),
  .dout_oe (dout_oe),
  .run     (run),
  .cfg     (cfg),
  .cmp_res (cmp_res),
  .cmp_vld (cmp_vld)
);

// File: tb/tb_setpoint_cmp.sv
module tb_setpoint_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic [31:0] ain = '0;
  logic [15:0] ain2 = '0;
  logic [7:0]  com_in = '0;
  logic        dout, dout_oe, dout2, oe2;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  setpoint_cmp dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
    .ain(ain), .com_in(com_in), .dout(dout), .dout_oe(dout_oe)
  );

  setpoint_cmp #(.NCH(2)) dut2 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
    .ain(ain2), .com_in(com_in), .dout(dout2), .dout_oe(oe2)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  function automatic logic expect_res(input int p, input int n, input int t);
    return (p - n) > t;
  endfunction

  task automatic set_ch(input int i, input logic [7:0] v);
    ain[i*8 +: 8] = v;
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    sdi  = 1'b0;
    @(posedge clk); #2;
  endtask

  task automatic send_word(input logic diff, input logic odd, input logic sel,
                           input logic com, input logic [7:0] thr, input int lead);
    logic [12:0] w;
    w = {1'b1, diff, odd, sel, com, thr};
    cs_n = 1'b0;
    for (int i = 0; i < lead; i++) begin
      sdi = 1'b0;
      @(posedge clk); #2;
    end
    for (int i = 12; i >= 0; i--) begin
      sdi = w[i];
      @(posedge clk); #2;
    end
    sdi = 1'b0;
  endtask

  // one compare edge, then the falling edge that shows it
  task automatic chk_out(input string req, input logic exp);
    @(posedge clk); @(negedge clk); #3;
    chk(req, dout_oe, 1'b1);
    chk(req, dout, exp);
  endtask

  task automatic t_single();
    end_frame();
    ain = '0; set_ch(2, 8'd150);
    send_word(1'b0, 1'b0, 1'b1, 1'b0, 8'd100, 3);  // R2 leading zeros, ch2
    chk_out("R3 single ch2 150>100", expect_res(150, 0, 100));
    set_ch(2, 8'd100);
    chk_out("R8 continuous equal", expect_res(100, 0, 100));
    set_ch(2, 8'd101);
    chk_out("R8 continuous above", 1'b1);
    set_ch(2, 8'd0);
    chk_out("R8 continuous zero", 1'b0);
  endtask

  task automatic t_pseudo();
    end_frame();
    ain = '0; set_ch(1, 8'd100); set_ch(0, 8'd255); com_in = 8'd60;
    send_word(1'b0, 1'b1, 1'b0, 1'b1, 8'd30, 0);
    chk_out("R4 pseudo 100-60>30", expect_res(100, 60, 30));
    com_in = 8'd70;
    chk_out("R4 pseudo diff equal thr", expect_res(100, 70, 30));
    com_in = 8'd120;
    chk_out("R6 pseudo neg above pos", 1'b0);
  endtask

  task automatic t_diff();
    end_frame();
    ain = '0; set_ch(2, 8'd90); set_ch(3, 8'd40); com_in = 8'd0;
    send_word(1'b1, 1'b0, 1'b1, 1'b0, 8'd49, 1);
    chk_out("R5 diff ch2-ch3", expect_res(90, 40, 49));
    end_frame();
    send_word(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 0);
    chk_out("R5 diff swapped ch3-ch2", expect_res(40, 90, 0));
    set_ch(3, 8'd90);
    chk_out("R6 diff equal inputs", 1'b0);
  endtask

  task automatic t_bounds();
    end_frame();
    ain = '0; set_ch(0, 8'd255); set_ch(1, 8'd255);
    send_word(1'b0, 1'b0, 1'b0, 1'b0, 8'd255, 0);
    chk_out("R6 full scale vs thr 255", 1'b0);
    end_frame();
    send_word(1'b0, 1'b0, 1'b0, 1'b0, 8'd254, 0);
    chk_out("R6 full scale vs thr 254", 1'b1);
    end_frame();
    set_ch(0, 8'd0);
    send_word(1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 0);
    chk_out("R6 zero vs thr 0", 1'b0);
    set_ch(0, 8'd1);
    chk_out("R6 one vs thr 0", 1'b1);
  endtask

  task automatic t_timing();
    end_frame();
    ain = '0; set_ch(0, 8'd200);
    send_word(1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 0);
    // last bit just taken; first compare edge not yet reached
    @(negedge clk); #3;
    chk("R7 no result before first compare edge", dout, 1'b0);
    @(posedge clk); #2;
    chk("R7 still low between compare edge and fall", dout, 1'b0);
    @(negedge clk); #3;
    chk("R7 result at falling edge", dout, 1'b1);
  endtask

  task automatic t_abort();
    logic [4:0] part;
    end_frame();
    ain = '0; set_ch(0, 8'd200);
    part = 5'b10000;
    cs_n = 1'b0;
    for (int i = 4; i >= 0; i--) begin
      sdi = part[i];
      @(posedge clk); #2;
    end
    @(negedge clk); #3;
    chk("R10 driven mid-word", dout_oe, 1'b1);
    chk("R10 low mid-word", dout, 1'b0);
    cs_n = 1'b1;
    #1;
    chk("R9 float on deselect", dout_oe, 1'b0);
    @(posedge clk); #2;
    cs_n = 1'b0;
    sdi  = 1'b0;
    #1;
    chk("R9 float until rising edge", dout_oe, 1'b0);
    @(posedge clk); #2;
    chk("R9 driven after rising edge", dout_oe, 1'b1);
    repeat (16) @(posedge clk);
    @(negedge clk); #3;
    chk("R11 partial word discarded", dout, 1'b0);
    send_word(1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 0);
    chk_out("R11 new word after abort", 1'b1);
    end_frame();
    cs_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); #3;
    chk("R11 run cleared by deselect", dout, 1'b0);
  endtask

  task automatic t_dual();
    end_frame();
    ain = '0; set_ch(3, 8'd5); com_in = 8'd200;
    ain2 = '0; ain2[15:8] = 8'd50;
    send_word(1'b0, 1'b1, 1'b1, 1'b1, 8'd10, 0);
    chk_out("R4 quad ch3 vs com", expect_res(5, 200, 10));
    chk("R12 dual ignores sel and com", dout2, expect_res(50, 0, 10));
    end_frame();
    ain2[7:0] = 8'd40;
    send_word(1'b1, 1'b1, 1'b1, 1'b0, 8'd5, 0);
    chk_out("R5 quad pair ch3-ch2", expect_res(5, 0, 5));
    chk("R12 dual diff pair 0/1", dout2, expect_res(50, 40, 5));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset dout", dout, 1'b0);
    chk("R1 reset oe", dout_oe, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    t_single();
    t_pseudo();
    t_diff();
    t_bounds();
    t_timing();
    t_abort();
    t_dual();
    end_frame();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule